// File: doc/BRIEF.md
# Identification-Code Command Gate

This block sits between a serial byte receiver and a flash command handler and decides which host commands reach the handler. It holds no copy of the code. Instead it compares a 7-byte identification code, which the host supplies one byte per code command, with the stored code that arrives on an input bus. It passes data commands on only once the whole sequence has matched. When the memory-blank flag is high, the comparison is skipped and commands pass without it.

A second check applies whatever the lock state is. Program and erase commands whose address falls at or above a parameterised boot-region base are refused, so only the user region can be modified. Read and status commands may address either region. Each command gets a registered result one clock later. An accepted command appears on the forward outputs together with a one-cycle accept pulse. A refused command raises a one-cycle reject pulse and is not forwarded.

Top module: `idgate_top`

## Requirements
- R1: After reset, fwd_valid, accept and reject are 0 and unlocked is 0.
- R2: With blank=0 and unlocked=0, every read (op 0), program (op 1), erase (op 2) and status (op 3) command is refused. The cycle after the command, reject=1 and fwd_valid=0.
- R3: An allowed data command gives accept=1 and fwd_valid=1 the cycle after it is presented. In that cycle fwd_op and fwd_addr equal the command's op and address. A data command is allowed when blank=1 or unlocked=1, provided R7 does not refuse it.
- R4: Code commands (op 4) carry one byte each on cmd_data. Byte k of a sequence is compared with stored_code[8k+7:8k], for k = 0..6. If all seven bytes match, then after the seventh byte unlocked=1 and accept=1 for one cycle.
- R5: If any byte of a sequence mismatches, the seventh byte gives reject=1 and unlocked stays 0. Code bytes 0 to 5 produce no accept and no reject pulse, and no code command is ever forwarded.
- R6: Once unlocked, the gate stays unlocked until reset or until the first byte of a new code sequence. That first byte clears unlocked on the next cycle.
- R7: A program or erase whose address is at or above BOOT_BASE is refused, even when unlocked=1 or blank=1. A read or status command to such an address follows the normal lock rules.
- R8: Op values 5, 6 and 7 are always refused with a reject pulse.
- R9: accept and reject are never high together, each lasts one cycle per command, and fwd_valid is high only together with accept.
- R10: A cycle without cmd_valid produces no accept, reject or fwd_valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0 read, 1 program, 2 erase, 3 status, 4 code byte) |
| cmd_addr | input | ADDR_W | Target address of the command |
| cmd_data | input | 8 | Code byte for op 4 |
| blank | input | 1 | Protected memory holds no data |
| stored_code | input | 56 | Stored identification code, byte 0 in bits 7:0 |
| fwd_valid | output | 1 | Forwarded command valid |
| fwd_op | output | 3 | Forwarded command code |
| fwd_addr | output | ADDR_W | Forwarded address |
| accept | output | 1 | One-cycle accept pulse |
| reject | output | 1 | One-cycle reject pulse |
| unlocked | output | 1 | Code sequence has matched |

## Verification
The bench sweeps every op value, with addresses on both sides of the boot base, through all four combinations of the blank flag and the lock state. This catches a gate that lets reads through while locked, or one that uses an off-by-one boundary at BOOT_BASE. It runs a code sequence with a wrong byte at each of the seven positions, in turn. A comparator that skips a byte or only checks the last one would unlock on one of those runs. It also restarts a sequence from the unlocked state, because a design that keeps its old unlock until the sequence ends would still forward commands in between.

// File: rtl/idgate_pkg.sv
package idgate_pkg;
    localparam int OP_W = 3;
    localparam logic [OP_W-1:0] OP_READ  = 3'd0;
    localparam logic [OP_W-1:0] OP_PROG  = 3'd1;
    localparam logic [OP_W-1:0] OP_ERASE = 3'd2;
    localparam logic [OP_W-1:0] OP_STAT  = 3'd3;
    localparam logic [OP_W-1:0] OP_CODE  = 3'd4;
endpackage

// File: rtl/idgate_classify.sv
module idgate_classify
    import idgate_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 12'hF00
) (
    input  logic [OP_W-1:0]   op,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_code,
    output logic              is_data,
    output logic              is_modify,
    output logic              in_boot
);
    always_comb begin
        is_code   = (op == OP_CODE);
        is_data   = (op == OP_READ) || (op == OP_PROG) ||
                    (op == OP_ERASE) || (op == OP_STAT);
        is_modify = (op == OP_PROG) || (op == OP_ERASE);
        in_boot   = (addr >= BOOT_BASE);
    end
endmodule

// File: rtl/idgate_bytesel.sv
module idgate_bytesel #(
    parameter int CODE_LEN = 7,
    parameter int BYTE_W   = 8,
    localparam int IDX_W   = $clog2(CODE_LEN)
) (
    input  logic [CODE_LEN*BYTE_W-1:0] code,
    input  logic [IDX_W-1:0]           idx,
    output logic [BYTE_W-1:0]          sel
);
    logic [BYTE_W-1:0] bytes [CODE_LEN];

    for (genvar g = 0; g < CODE_LEN; g++) begin : g_split
        assign bytes[g] = code[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < CODE_LEN; i++) begin
            if (idx == IDX_W'(i)) sel = bytes[i];
        end
    end
endmodule

// File: rtl/idgate_top.sv
module idgate_top
    import idgate_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int CODE_LEN = 7,
    parameter int BYTE_W   = 8,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 12'hF00
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [OP_W-1:0]            cmd_op,
    input  logic [ADDR_W-1:0]          cmd_addr,
    input  logic [BYTE_W-1:0]          cmd_data,
    input  logic                       blank,
    input  logic [CODE_LEN*BYTE_W-1:0] stored_code,
    output logic                       fwd_valid,
    output logic [OP_W-1:0]            fwd_op,
    output logic [ADDR_W-1:0]          fwd_addr,
    output logic                       accept,
    output logic                       reject,
    output logic                       unlocked
);
    localparam int IDX_W = $clog2(CODE_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_LEN - 1);

    typedef struct packed {
        logic              unl;
        logic              run_ok;
        logic [IDX_W-1:0]  idx;
        logic              fwd_v;
        logic [OP_W-1:0]   fwd_op;
        logic [ADDR_W-1:0] fwd_addr;
        logic              acc;
        logic              rej;
    } gate_st_t;

    gate_st_t st_d, st_q;

    logic is_code, is_data, is_modify, in_boot;
    logic [BYTE_W-1:0] exp_byte;
    logic byte_eq, seq_ok, allowed;

    idgate_classify #(.ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE)) u_classify (
        .op        (cmd_op),
        .addr      (cmd_addr),
        .is_code   (is_code),
        .is_data   (is_data),
        .is_modify (is_modify),
        .in_boot   (in_boot)
    );

    idgate_bytesel #(.CODE_LEN(CODE_LEN), .BYTE_W(BYTE_W)) u_bytesel (
        .code (stored_code),
        .idx  (st_q.idx),
        .sel  (exp_byte)
    );

    always_comb begin
        byte_eq = (cmd_data == exp_byte);
        seq_ok  = ((st_q.idx == '0) || st_q.run_ok) && byte_eq;
        allowed = is_data && (st_q.unl || blank) && !(is_modify && in_boot);

        st_d       = st_q;
        st_d.fwd_v = 1'b0;
        st_d.acc   = 1'b0;
        st_d.rej   = 1'b0;

        if (cmd_valid) begin
            if (is_code) begin
                st_d.run_ok = seq_ok;
                if (st_q.idx == '0) st_d.unl = 1'b0;
                if (st_q.idx == LAST_IDX) begin
                    st_d.idx = '0;
                    st_d.unl = seq_ok;
                    st_d.acc = seq_ok;
                    st_d.rej = !seq_ok;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end else if (allowed) begin
                st_d.fwd_v    = 1'b1;
                st_d.fwd_op   = cmd_op;
                st_d.fwd_addr = cmd_addr;
                st_d.acc      = 1'b1;
            end else begin
                st_d.rej = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fwd_valid = st_q.fwd_v;
    assign fwd_op    = st_q.fwd_op;
    assign fwd_addr  = st_q.fwd_addr;
    assign accept    = st_q.acc;
    assign reject    = st_q.rej;
    assign unlocked  = st_q.unl;
endmodule

// File: rtl/idgate_chk.sv
module idgate_chk
    import idgate_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 12'hF00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [OP_W-1:0]   cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              blank,
    input logic              fwd_valid,
    input logic              accept,
    input logic              reject,
    input logic              unlocked
);
    // R2
    locked_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !blank && !unlocked && (cmd_op < OP_CODE) |=> reject && !fwd_valid);

    // R6
    unlock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked && !(cmd_valid && cmd_op == OP_CODE) |=> unlocked);

    // R7
    boot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_op == OP_PROG || cmd_op == OP_ERASE) && cmd_addr >= BOOT_BASE
        |=> reject && !fwd_valid);

    // R8
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op > OP_CODE |=> reject);

    // R9
    excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({accept, reject}));

    // R9
    fwd_with_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> accept);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !accept && !reject && !fwd_valid);
endmodule

bind idgate_top idgate_chk #(.ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .blank     (blank),
    .fwd_valid (fwd_valid),
    .accept    (accept),
    .reject    (reject),
    .unlocked  (unlocked)
);

// File: tb/tb_idgate_top.sv
module tb_idgate_top;
    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] BOOT = 12'hF00;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0]        cmd_data = '0;
    logic              blank = 1'b0;
    logic [55:0]       stored_code;
    logic              fwd_valid, accept, reject, unlocked;
    logic [2:0]        fwd_op;
    logic [ADDR_W-1:0] fwd_addr;

    int n_vec = 0;
    int n_bad = 0;
    logic unl_m = 1'b0;

    always #5 clk = ~clk;

    idgate_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .blank(blank),
        .stored_code(stored_code), .fwd_valid(fwd_valid), .fwd_op(fwd_op),
        .fwd_addr(fwd_addr), .accept(accept), .reject(reject), .unlocked(unlocked)
    );

    function automatic logic [7:0] code_byte(int k);
        return 8'(8'h3C + 17 * k);
    endfunction

    initial for (int k = 0; k < 7; k++) stored_code[k*8 +: 8] = code_byte(k);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // present one command at a negedge, sample at the following negedge
    task automatic issue(logic [2:0] op, logic [ADDR_W-1:0] a, logic [7:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic data_cmd(logic [2:0] op, logic [ADDR_W-1:0] a);
        logic ok;
        ok = (op < 3'd4) && (blank || unl_m) && !((op == 3'd1 || op == 3'd2) && a >= BOOT);
        issue(op, a, 8'h00);
        if (op > 3'd4) check("R8 reject", {31'd0, reject}, 32'd1);
        else if (!blank && !unl_m) check("R2 reject", {31'd0, reject}, 32'd1);
        else if ((op == 3'd1 || op == 3'd2) && a >= BOOT) check("R7 reject", {31'd0, reject}, 32'd1);
        check("R3 accept", {31'd0, accept}, {31'd0, ok});
        check("R9 fwd_valid", {31'd0, fwd_valid}, {31'd0, ok});
        check("R9 reject", {31'd0, reject}, {31'd0, !ok});
        if (ok) check("R3 fwd", {17'd0, fwd_op, fwd_addr}, {17'd0, op, a});
        check("R6 unlocked", {31'd0, unlocked}, {31'd0, unl_m});
    endtask

    // send a 7-byte sequence; bad_pos<0 means all bytes correct
    task automatic code_seq(int bad_pos);
        for (int k = 0; k < 7; k++) begin
            logic [7:0] b;
            b = code_byte(k) ^ ((k == bad_pos) ? 8'h5A : 8'h00);
            issue(3'd4, 12'h000, b);
            if (k < 6) begin
                check("R5 no pulse", {30'd0, accept, reject}, 32'd0);
                check("R5 no fwd", {31'd0, fwd_valid}, 32'd0);
                check("R6 cleared", {31'd0, unlocked}, 32'd0);
            end else begin
                check("R4 accept", {31'd0, accept}, {31'd0, bad_pos < 0});
                check("R5 reject", {31'd0, reject}, {31'd0, bad_pos >= 0});
                check("R4 unlocked", {31'd0, unlocked}, {31'd0, bad_pos < 0});
            end
        end
        unl_m = (bad_pos < 0);
    endtask

    task automatic sweep();
        logic [ADDR_W-1:0] addrs [4];
        addrs[0] = 12'h000; addrs[1] = BOOT - 1; addrs[2] = BOOT; addrs[3] = 12'hFFF;
        for (int op = 0; op < 8; op++) begin
            if (op != 4) begin
                for (int ai = 0; ai < 4; ai++) data_cmd(3'(op), addrs[ai]);
            end
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pulses", {29'd0, fwd_valid, accept, reject}, 32'd0);
        check("R1 unlocked", {31'd0, unlocked}, 32'd0);

        // R10: idle cycles give nothing
        @(negedge clk);
        check("R10 idle", {29'd0, fwd_valid, accept, reject}, 32'd0);

        // locked, not blank, then blank bypass
        blank = 1'b0; sweep();
        blank = 1'b1; sweep();
        blank = 1'b0;

        // wrong byte at each position in turn (R5)
        for (int p = 0; p < 7; p++) begin
            code_seq(p);
            data_cmd(3'd0, 12'h010);
        end

        // correct sequence, then unlocked sweeps (R4, R6, R7)
        code_seq(-1);
        sweep();
        blank = 1'b1; sweep(); blank = 1'b0;
        @(negedge clk);
        check("R6 persists", {31'd0, unlocked}, 32'd1);

        // restart: first byte clears unlock at once (R6)
        issue(3'd4, 12'h000, code_byte(0));
        check("R6 restart clears", {31'd0, unlocked}, 32'd0);
        unl_m = 1'b0;
        data_cmd(3'd3, 12'h020);
        // finish the sequence correctly (bytes 1..6 continue the run)
        for (int k = 1; k < 7; k++) begin
            issue(3'd4, 12'h000, code_byte(k));
            if (k == 6) check("R4 resumed", {30'd0, accept, unlocked}, 32'd3);
        end
        unl_m = 1'b1;
        data_cmd(3'd1, 12'h100);

        // reset drops the unlock (R1)
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        unl_m = 1'b0;
        check("R1 relock", {31'd0, unlocked}, 32'd0);
        data_cmd(3'd0, 12'h000);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule